// File: doc/BRIEF.md
# Raster-Op Block Transfer Engine

The engine copies a rectangle of 8-bit pixels from one place in a byte-addressed video memory to another. It reaches that memory through a single request/ready port. Each destination pixel becomes a raster operation of a source pixel and the pixel already present at the destination. The source can be a plain byte stream, a monochrome bitmap expanded into two colours, or an 8×8 tile that repeats across the rectangle. A colour key can veto single writes. Rows can be walked upward in memory or downward, so that overlapping moves stay correct.

Software loads a small file of byte-wide registers and then sets the start bit. The engine walks the rectangle row by row. Per pixel it does a source read when a fresh source byte is needed, then a destination read, then a write. While the walk runs, the status bit reads 1 and the parameter registers refuse writes. A one-cycle `done` pulse marks the end of the walk.

Top module: `rop_blit_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `done` and `mem_req` are 0, and every register reads 0. A started transfer touches exactly (width+1) bytes in each of (height+1) rows.
- R2: Writing a byte with bit 1 set to offset 0x18 while idle starts a transfer. Bit 1 of offset 0x18 then reads 1 until the transfer ends and reads 0 afterwards. `done` is high for exactly one cycle per transfer, in the cycle after the last access.
- R3: The raster-op register (offset 0x11) selects the result from source S and destination D. The codes are: 0x0D S, 0x06 D, 0xD0 ~S, 0x0B ~D, 0x00 all zeros, 0x0E all ones, 0x05 S&D, 0x6D S|D, 0x59 S^D, 0xDA ~(S&D), 0x90 ~(S|D), 0x95 ~(S^D), 0x09 S&~D, 0x50 ~S&D, 0xAD S|~D, 0xD6 ~S|D. Any other code leaves D unchanged.
- R4: With mode (offset 0x10) bit 0 clear, row r starts at destination base + r×destination pitch and at source base + r×source pitch, and addresses rise by one per pixel.
- R5: With mode bit 0 set, row r starts at base − r×pitch and addresses fall by one per pixel. The arithmetic wraps modulo 2^ADDR_W.
- R6: With mode bit 7 set, each source byte supplies 8 pixels, most significant bit first. A 1 bit selects the foreground register (offset 0x16) and a 0 bit the background register (offset 0x17). The source moves on by one byte every 8 pixels.
- R7: With mode bit 6 set, the source for row r comes from a tile at the source base. With colour expansion that is the single byte base ± (r mod 8). Without it, pixel x reads base ± (8×(r mod 8) + (x mod 8)). The source pitch is not used.
- R8: With mode bit 3 set, a result is not written when (result & ~M) equals (K & ~M). K is the low byte of the key register (offsets 0x12/0x13) and M is the low byte of the key mask (offsets 0x14/0x15). The high bytes of K and M have no effect.
- R9: Every memory access holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until the cycle in which `mem_ready` is high, and it completes in that cycle.
- R10: While busy, writes to any register are ignored. This includes a second start.
- R11: Every register reads back what was last written to it while idle. The offsets are: width 0x00/0x01, height 0x02/0x03, destination pitch 0x04/0x05, source pitch 0x06/0x07, destination base 0x08–0x0A, source base 0x0C–0x0E, mode 0x10, raster-op 0x11, key 0x12/0x13, key mask 0x14/0x15, foreground 0x16, background 0x17. The low byte comes first. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the ready cycle |
| mem_ready | input | 1 | Access completes this cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at completion |

## Verification
The bench builds the engine with ADDR_W = 12 in front of a 4096-byte memory model. With that width, a backward walk from a low base wraps to the top of memory, which exercises the modular arithmetic of R5. The narrow address also lets a full comparison of the memory image catch any stray write outside the rectangle. A pseudo-random `mem_ready` stretches accesses by varying amounts, so the hold rule of R9 is exercised on reads and writes alike. Tiles taller than 8 rows and rows wider than 8 pixels bring the wrap of the pattern row and of the expansion bit index within reach.

// File: rtl/rop_blit_engine.sv
module rop_blit_engine #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [4:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ready,
  output logic              busy,
  output logic              done
);

  localparam logic [4:0] OFS_STAT = 5'h18;

  typedef enum logic [1:0] {ST_IDLE, ST_RSRC, ST_RDST, ST_WR} state_t;

  logic [15:0] cfg_w, cfg_h, dpitch, spitch, key, kmask;
  logic [23:0] dbase, sbase;
  logic [7:0]  mode, rop, fg, bg;

  state_t            state;
  logic [15:0]       x_cnt, y_cnt;
  logic [ADDR_W-1:0] row_s, row_d;
  logic [7:0]        sbyte, wbyte;

  wire back  = mode[0];
  wire tkey  = mode[3];
  wire pat   = mode[6];
  wire xpand = mode[7];

  wire acc    = mem_req && mem_ready;
  wire x_last = (x_cnt == cfg_w);
  wire y_last = (y_cnt == cfg_h);
  wire [15:0] nx = x_last ? 16'd0 : x_cnt + 16'd1;
  wire need_src_n = !xpand || (nx[2:0] == 3'd0);
  wire start_req  = reg_wr && !busy && (reg_addr == OFS_STAT) && reg_wdata[1];

  logic [ADDR_W-1:0] s_org, s_off, src_addr, dst_addr;
  always_comb begin
    if (pat) begin
      s_org = sbase[ADDR_W-1:0];
      s_off = xpand ? ADDR_W'(y_cnt[2:0]) : ADDR_W'({y_cnt[2:0], x_cnt[2:0]});
    end else begin
      s_org = row_s;
      s_off = xpand ? ADDR_W'(x_cnt[15:3]) : ADDR_W'(x_cnt);
    end
    src_addr = back ? s_org - s_off : s_org + s_off;
    dst_addr = back ? row_d - ADDR_W'(x_cnt) : row_d + ADDR_W'(x_cnt);
  end

  wire [7:0] s_pix = xpand ? (sbyte[~x_cnt[2:0]] ? fg : bg) : sbyte;
  wire [7:0] d_pix = mem_rdata;

  logic [7:0] rop_res;
  always_comb begin
    case (rop)
      8'h00:   rop_res = 8'h00;
      8'h05:   rop_res = s_pix & d_pix;
      8'h06:   rop_res = d_pix;
      8'h09:   rop_res = s_pix & ~d_pix;
      8'h0B:   rop_res = ~d_pix;
      8'h0D:   rop_res = s_pix;
      8'h0E:   rop_res = 8'hFF;
      8'h50:   rop_res = ~s_pix & d_pix;
      8'h59:   rop_res = s_pix ^ d_pix;
      8'h6D:   rop_res = s_pix | d_pix;
      8'h90:   rop_res = ~(s_pix | d_pix);
      8'h95:   rop_res = ~(s_pix ^ d_pix);
      8'hAD:   rop_res = s_pix | ~d_pix;
      8'hD0:   rop_res = ~s_pix;
      8'hD6:   rop_res = ~s_pix | d_pix;
      8'hDA:   rop_res = ~(s_pix & d_pix);
      default: rop_res = d_pix;
    endcase
  end

  wire key_hit = tkey && ((rop_res & ~kmask[7:0]) == (key[7:0] & ~kmask[7:0]));
  wire step    = acc && ((state == ST_WR) || (state == ST_RDST && key_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_w <= '0; cfg_h <= '0; dpitch <= '0; spitch <= '0;
      key <= '0; kmask <= '0; dbase <= '0; sbase <= '0;
      mode <= '0; rop <= '0; fg <= '0; bg <= '0;
    end else if (reg_wr && !busy) begin
      case (reg_addr)
        5'h00: cfg_w[7:0]   <= reg_wdata;
        5'h01: cfg_w[15:8]  <= reg_wdata;
        5'h02: cfg_h[7:0]   <= reg_wdata;
        5'h03: cfg_h[15:8]  <= reg_wdata;
        5'h04: dpitch[7:0]  <= reg_wdata;
        5'h05: dpitch[15:8] <= reg_wdata;
        5'h06: spitch[7:0]  <= reg_wdata;
        5'h07: spitch[15:8] <= reg_wdata;
        5'h08: dbase[7:0]   <= reg_wdata;
        5'h09: dbase[15:8]  <= reg_wdata;
        5'h0A: dbase[23:16] <= reg_wdata;
        5'h0C: sbase[7:0]   <= reg_wdata;
        5'h0D: sbase[15:8]  <= reg_wdata;
        5'h0E: sbase[23:16] <= reg_wdata;
        5'h10: mode         <= reg_wdata;
        5'h11: rop          <= reg_wdata;
        5'h12: key[7:0]     <= reg_wdata;
        5'h13: key[15:8]    <= reg_wdata;
        5'h14: kmask[7:0]   <= reg_wdata;
        5'h15: kmask[15:8]  <= reg_wdata;
        5'h16: fg           <= reg_wdata;
        5'h17: bg           <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      x_cnt <= '0; y_cnt <= '0;
      row_s <= '0; row_d <= '0;
      sbyte <= '0; wbyte <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start_req) begin
          x_cnt <= '0; y_cnt <= '0;
          row_s <= sbase[ADDR_W-1:0];
          row_d <= dbase[ADDR_W-1:0];
          state <= ST_RSRC;
        end
        ST_RSRC: if (acc) begin
          sbyte <= mem_rdata;
          state <= ST_RDST;
        end
        ST_RDST: if (acc) begin
          wbyte <= rop_res;
          if (!key_hit) state <= ST_WR;
        end
        default: ;
      endcase
      if (step) begin
        x_cnt <= nx;
        state <= need_src_n ? ST_RSRC : ST_RDST;
        if (x_last) begin
          if (y_last) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            y_cnt <= y_cnt + 16'd1;
            row_s <= back ? row_s - ADDR_W'(spitch) : row_s + ADDR_W'(spitch);
            row_d <= back ? row_d - ADDR_W'(dpitch) : row_d + ADDR_W'(dpitch);
          end
        end
      end
    end
  end

  assign busy      = (state != ST_IDLE);
  assign mem_req   = busy;
  assign mem_we    = (state == ST_WR);
  assign mem_addr  = (state == ST_RSRC) ? src_addr : dst_addr;
  assign mem_wdata = wbyte;

  always_comb begin
    case (reg_addr)
      5'h00: reg_rdata = cfg_w[7:0];
      5'h01: reg_rdata = cfg_w[15:8];
      5'h02: reg_rdata = cfg_h[7:0];
      5'h03: reg_rdata = cfg_h[15:8];
      5'h04: reg_rdata = dpitch[7:0];
      5'h05: reg_rdata = dpitch[15:8];
      5'h06: reg_rdata = spitch[7:0];
      5'h07: reg_rdata = spitch[15:8];
      5'h08: reg_rdata = dbase[7:0];
      5'h09: reg_rdata = dbase[15:8];
      5'h0A: reg_rdata = dbase[23:16];
      5'h0C: reg_rdata = sbase[7:0];
      5'h0D: reg_rdata = sbase[15:8];
      5'h0E: reg_rdata = sbase[23:16];
      5'h10: reg_rdata = mode;
      5'h11: reg_rdata = rop;
      5'h12: reg_rdata = key[7:0];
      5'h13: reg_rdata = key[15:8];
      5'h14: reg_rdata = kmask[7:0];
      5'h15: reg_rdata = kmask[15:8];
      5'h16: reg_rdata = fg;
      5'h17: reg_rdata = bg;
      5'h18: reg_rdata = {6'b0, busy, 1'b0};
      default: reg_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/blit_engine_chk.sv
module blit_engine_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [4:0]        reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              mem_ready,
  input logic              busy,
  input logic              done
);

  p_hold_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_end_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !busy && reg_addr == 5'h18 && reg_wdata[1] |=> busy);

  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_req);

endmodule

bind rop_blit_engine blit_engine_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ready(mem_ready), .busy(busy), .done(done)
);

// File: tb/rop_blit_engine_tb_top.sv
`timescale 1ns/1ps
module rop_blit_engine_tb_top;
  localparam int AW = 12;
  localparam int MSZ = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, mem_ready, busy, done;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  rop_blit_engine #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready), .busy(busy), .done(done)
  );

  logic [7:0] mem [0:MSZ-1];
  logic [7:0] model [0:MSZ-1];
  logic fill_go = 1'b0, poke_en = 1'b0;
  int fill_seed = 0;
  logic [AW-1:0] poke_addr = '0;
  logic [7:0] poke_data = '0;

  function automatic logic [7:0] hsh(int i, int sd);
    return 8'((i * 37 + sd * 101) ^ (i >> 4));
  endfunction

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    if (fill_go) begin
      for (int i = 0; i < MSZ; i++) mem[i] <= hsh(i, fill_seed);
    end else if (poke_en) mem[poke_addr] <= poke_data;
    else if (mem_req && mem_ready && mem_we) mem[mem_addr] <= mem_wdata;
  end

  logic [7:0] lfsr = 8'hA5;
  always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  assign mem_ready = lfsr[0] | lfsr[2];

  int done_cnt = 0;
  always @(negedge clk) if (done) done_cnt++;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // shadow of programmed parameters
  int w, h, dp, sp, db, sb, md, rp, kc, km, fgc, bgc;

  task automatic reg_write(logic [4:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic fill(int seed);
    @(negedge clk); fill_seed = seed; fill_go = 1'b1;
    @(negedge clk); fill_go = 1'b0;
    for (int i = 0; i < MSZ; i++) model[i] = hsh(i, seed);
  endtask

  task automatic poke(int a, logic [7:0] d);
    @(negedge clk); poke_en = 1'b1; poke_addr = AW'(a); poke_data = d;
    @(negedge clk); poke_en = 1'b0;
    model[a] = d;
  endtask

  function automatic logic [7:0] rop_f(int code, logic [7:0] s, logic [7:0] d);
    case (code)
      8'h00: return 8'h00;   8'h05: return s & d;     8'h06: return d;
      8'h09: return s & ~d;  8'h0B: return ~d;        8'h0D: return s;
      8'h0E: return 8'hFF;   8'h50: return ~s & d;    8'h59: return s ^ d;
      8'h6D: return s | d;   8'h90: return ~(s | d);  8'h95: return ~(s ^ d);
      8'hAD: return s | ~d;  8'hD0: return ~s;        8'hD6: return ~s | d;
      8'hDA: return ~(s & d);
      default: return d;
    endcase
  endfunction

  task automatic model_run();
    bit bk, xp, pt;
    bk = md[0]; xp = md[7]; pt = md[6];
    for (int r = 0; r <= h; r++) begin
      for (int x = 0; x <= w; x++) begin
        int so, sorg, rs, rd;
        logic [AW-1:0] sa, da;
        logic [7:0] s, d, res, sbyte;
        rs = bk ? sb - sp * r : sb + sp * r;
        rd = bk ? db - dp * r : db + dp * r;
        if (pt) begin sorg = sb; so = xp ? r % 8 : 8 * (r % 8) + x % 8; end
        else begin sorg = rs; so = xp ? x / 8 : x; end
        sa = AW'(bk ? sorg - so : sorg + so);
        da = AW'(bk ? rd - x : rd + x);
        sbyte = model[sa];
        s = xp ? (sbyte[7 - x % 8] ? 8'(fgc) : 8'(bgc)) : sbyte;
        d = model[da];
        res = rop_f(rp, s, d);
        if (!(md[3] && ((res & ~km[7:0]) == (kc[7:0] & ~km[7:0])))) model[da] = res;
      end
    end
  endtask

  function automatic logic [7:0] exp_reg(int a);
    case (a)
      0: return w[7:0];    1: return w[15:8];   2: return h[7:0];    3: return h[15:8];
      4: return dp[7:0];   5: return dp[15:8];  6: return sp[7:0];   7: return sp[15:8];
      8: return db[7:0];   9: return db[15:8];  10: return db[23:16];
      12: return sb[7:0];  13: return sb[15:8]; 14: return sb[23:16];
      16: return md[7:0];  17: return rp[7:0];  18: return kc[7:0];  19: return kc[15:8];
      20: return km[7:0];  21: return km[15:8]; 22: return fgc[7:0]; 23: return bgc[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic set_regs();
    for (int a = 0; a < 24; a++)
      if (a != 11 && a != 15) reg_write(5'(a), exp_reg(a));
  endtask

  task automatic start_blit(string tag);
    logic [7:0] st;
    reg_write(5'h18, 8'h02);
    reg_read(5'h18, st);
    check(st[1] == 1'b1, {tag, " R2 busy bit set"}, st, 8'h02);
  endtask

  task automatic finish_blit(string tag, int dc0);
    logic [7:0] st;
    int mism, fa, fe;
    for (int t = 0; t < 40000 && done_cnt == dc0; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    reg_read(5'h18, st);
    check(st == 8'h00, {tag, " R2 status clear"}, st, 0);
    check(done_cnt == dc0 + 1, {tag, " R2 single done"}, done_cnt - dc0, 1);
    mism = 0; fa = 0; fe = 0;
    for (int i = 0; i < MSZ; i++)
      if (mem[i] !== model[i]) begin
        if (mism == 0) begin fa = {i, mem[i]}; fe = {i, model[i]}; end
        mism++;
      end
    check(mism == 0, {tag, " memory image"}, fa, fe);
  endtask

  task automatic blit(string tag);
    int dc0;
    set_regs();
    model_run();
    dc0 = done_cnt;
    start_blit(tag);
    finish_blit(tag, dc0);
  endtask

  task automatic defaults();
    w = 0; h = 0; dp = 0; sp = 0; db = 0; sb = 0; md = 0; rp = 8'h0D;
    kc = 0; km = 0; fgc = 0; bgc = 0;
  endtask

  localparam logic [15:0] ROPV [17] = '{
    16'h00_00, 16'h05_48, 16'h06_5C, 16'h09_82, 16'h0B_A3, 16'h0D_CA,
    16'h0E_FF, 16'h50_14, 16'h59_96, 16'h6D_DE, 16'h90_21, 16'h95_69,
    16'hAD_EB, 16'hD0_35, 16'hD6_7D, 16'hDA_B7, 16'h33_5C
  };

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R2: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int dc0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !mem_req, "R1 reset outputs", {busy, done, mem_req}, 0);
    reg_read(5'h18, rd); check(rd == 8'h00, "R1 reset status", rd, 0);
    reg_read(5'h00, rd); check(rd == 8'h00, "R1 reset width", rd, 0);

    // R3 raster-op table: S=0xCA at 0x010, D=0x5C at 0x020
    fill(1);
    for (int v = 0; v < 17; v++) begin
      defaults();
      poke(12'h010, 8'hCA); poke(12'h020, 8'h5C);
      sb = 12'h010; db = 12'h020; rp = ROPV[v][15:8];
      set_regs();
      dc0 = done_cnt;
      reg_write(5'h18, 8'h02);
      for (int t = 0; t < 1000 && done_cnt == dc0; t++) @(negedge clk);
      @(negedge clk);
      check(mem[12'h020] == ROPV[v][7:0], $sformatf("R3 rop %02h", ROPV[v][15:8]), mem[12'h020], ROPV[v][7:0]);
    end

    // R1 R4 forward rectangle
    fill(2); defaults();
    w = 3; h = 2; dp = 16; sp = 20; db = 12'h200; sb = 12'h100;
    blit("R1 R4 forward");
    // R11 readback of everything programmed
    for (int a = 0; a < 24; a++) begin
      reg_read(5'(a), rd);
      check(rd == exp_reg(a), $sformatf("R11 readback %02h", a), rd, exp_reg(a));
    end

    // R5 backward, and backward wrap below zero
    fill(3); defaults();
    md = 8'h01; w = 5; h = 3; dp = 32; sp = 24; db = 12'h320; sb = 12'h2A0; rp = 8'h59;
    blit("R5 backward");
    defaults(); md = 8'h01; w = 7; h = 1; dp = 16; sp = 16; db = 12'h005; sb = 12'h600;
    blit("R5 backward wrap");

    // R6 colour expansion, forward and backward
    fill(4); defaults();
    md = 8'h80; w = 19; h = 2; sb = 12'h400; sp = 4; db = 12'h500; dp = 32; fgc = 8'hE1; bgc = 8'h1E;
    blit("R6 expand forward");
    md = 8'h81; db = 12'h5F0; sb = 12'h43F; rp = 8'h6D;
    blit("R6 expand backward");

    // R7 pattern copy with rows past 8 and columns past 8
    fill(5); defaults();
    md = 8'h40; w = 11; h = 9; sb = 12'h600; db = 12'h700; dp = 16;
    blit("R7 pattern");
    md = 8'hC0; w = 15; h = 10; sb = 12'h680; db = 12'h800; dp = 20; fgc = 8'h77; bgc = 8'h88;
    blit("R7 pattern expand");
    md = 8'h41; w = 9; h = 8; sb = 12'h6C0; db = 12'h9F0; dp = 16; rp = 8'h95;
    blit("R7 pattern backward");

    // R8 transparency: high bytes of key and mask set to values that would matter
    fill(6); defaults();
    md = 8'h08; w = 15; h = 3; sb = 12'hA00; sp = 16; db = 12'hB00; dp = 16;
    kc = 16'h775A; km = 16'hFFFC;
    blit("R8 key copy");
    md = 8'h08; rp = 8'h59; kc = 16'h0033; km = 16'h00F0;
    blit("R8 key on result");
    md = 8'h88; rp = 8'h0D; fgc = 8'h3C; bgc = 8'hC3; kc = 16'h003C; km = 16'h0000; sp = 2; w = 15;
    blit("R8 key expand");
    check(mem[12'hB00] == model[12'hB00], "R8 R9 first pixel", mem[12'hB00], model[12'hB00]);

    // R10 writes while busy are ignored
    fill(7); defaults();
    w = 39; h = 3; sb = 12'hC00; sp = 40; db = 12'hD00; dp = 48; rp = 8'hD0;
    set_regs(); model_run();
    dc0 = done_cnt;
    start_blit("R10");
    reg_write(5'h00, 8'h05);
    reg_write(5'h10, 8'h01);
    reg_write(5'h18, 8'h02);
    finish_blit("R10", dc0);
    reg_read(5'h00, rd); check(rd == 8'd39, "R10 width kept", rd, 39);
    reg_read(5'h10, rd); check(rd == 8'h00, "R10 mode kept", rd, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule